// File: doc/BRIEF.md
# Interleaved SRAM Framebuffer Scanout Controller

This block drives a 640x480, 60 Hz raster from a byte-wide asynchronous SRAM that holds one byte per pixel. The same SRAM is filled by a host that streams pixel bytes over a serial-peripheral slave port. The core clock runs at twice the pixel rate, and the two core cycles of each pixel period are given fixed jobs. The first cycle is a display read, and its data is caught in the single on-chip pixel register. The second cycle is a host write, if a received byte is waiting.

Host bytes arrive in SPI mode 0, most significant bit first. Each chip-select assertion restarts the write position at the top-left pixel. Every complete byte goes to the next pixel address, and the address wraps after the last pixel of the frame. SCK, chip select and MOSI are oversampled in the core clock domain. Sync pulses are active low and are produced by comparing the line and pixel counters against fixed window limits. The pixel output is forced to zero outside the visible area.

Top module: `sram_fb_scanout`

## Requirements
- R1: While rst_ni is low, pix_o is 0, hsync_no and vsync_no are 1, and sram_we_no is 1.
- R2: Counting core cycles from reset release as 0, 1, 2, ..., sram_oe_no is low only in even cycles and sram_we_no is low only in odd cycles. The two strobes are never low in the same cycle.
- R3: In the read cycle of pixel (h, v) inside the visible area, sram_oe_no is low and sram_addr_o equals v*H_ACT+h. The byte on sram_dq_i at the end of that cycle appears on pix_o from the next clock edge.
- R4: For a pixel period outside the visible area, sram_oe_no stays high and pix_o is 0 from the end of its read cycle.
- R5: hsync_no is low for the H_SW pixel columns that start at column H_ACT+H_FP, and high otherwise. It is registered together with pix_o.
- R6: vsync_no is low for the V_SW lines that start at line V_ACT+V_FP, and high otherwise. It is registered together with pix_o.
- R7: Bits on spi_mosi_i are sampled on rising spi_sck_i while spi_cs_ni is low, with the first bit taken as bit 7. Each completed byte is written once, with that value on sram_dq_o, in a following write cycle.
- R8: A falling spi_cs_ni sets the write address to 0 and discards any bits of an incomplete byte.
- R9: Each completed byte goes to the address after the previous one. After address H_ACT*V_ACT-1, the next byte goes to address 0.
- R10: SCK edges while spi_cs_ni is high cause no SRAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, twice the pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_sck_i | input | 1 | Serial clock from host |
| spi_cs_ni | input | 1 | Chip select from host, active low |
| spi_mosi_i | input | 1 | Serial data from host |
| sram_addr_o | output | ADDR_W | SRAM address |
| sram_dq_i | input | PIX_W | SRAM read data |
| sram_dq_o | output | PIX_W | SRAM write data |
| sram_oe_no | output | 1 | SRAM output enable, active low |
| sram_we_no | output | 1 | SRAM write enable, active low |
| pix_o | output | PIX_W | Pixel byte to the DAC |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low |

## Verification
The hardest case to reach from the ports is the write-address wrap. It only happens after a full frame of bytes has arrived in one chip-select window. The bench therefore builds the controller with a shrunken raster of 8x6 visible pixels and streams 50 bytes in one transfer, so two writes land back at addresses 0 and 1. It also drops chip select in the middle of a byte before a fresh transfer, to show that the stray bits and the old address are discarded. Every write the SRAM model sees is matched against a queue of the bytes sent, and every displayed pixel is matched against the model memory.

// File: rtl/sram_fb_pkg.sv
package sram_fb_pkg;
  // Fixed job of each core cycle within a pixel period
  typedef enum logic {
    SLOT_RD = 1'b0,
    SLOT_WR = 1'b1
  } slot_e;
endpackage

// File: rtl/fb_spi_rx.sv
module fb_spi_rx #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              start_o,
  output logic              byte_vld_o,
  output logic [DATA_W-1:0] byte_o
);
  logic [2:0]        sck_sr, cs_sr;
  logic [1:0]        mosi_sr;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic              sck_rise, cs_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sr  <= '0;
      cs_sr   <= '1;
      mosi_sr <= '0;
    end else begin
      sck_sr  <= {sck_sr[1:0], sck_i};
      cs_sr   <= {cs_sr[1:0], cs_ni};
      mosi_sr <= {mosi_sr[0], mosi_i};
    end
  end

  assign sck_rise = sck_sr[1] & ~sck_sr[2];
  assign cs_act   = ~cs_sr[1];
  assign start_o  = cs_sr[2] & ~cs_sr[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (!cs_act || start_o) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        shreg <= {shreg[DATA_W-2:0], mosi_sr[1]};
        if (bit_cnt == CNT_W'(DATA_W-1)) begin
          bit_cnt    <= '0;
          byte_vld_o <= 1'b1;
          byte_o     <= {shreg[DATA_W-2:0], mosi_sr[1]};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assert_byte_in_cs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> !$past(cs_sr[1]));
endmodule

// File: rtl/fb_raster.sv
module fb_raster #(
  parameter int unsigned H_ACT = 640,
  parameter int unsigned H_FP  = 16,
  parameter int unsigned H_SW  = 96,
  parameter int unsigned H_BP  = 48,
  parameter int unsigned V_ACT = 480,
  parameter int unsigned V_FP  = 10,
  parameter int unsigned V_SW  = 2,
  parameter int unsigned V_BP  = 33,
  localparam int unsigned H_TOT = H_ACT + H_FP + H_SW + H_BP,
  localparam int unsigned V_TOT = V_ACT + V_FP + V_SW + V_BP,
  localparam int unsigned HW = $clog2(H_TOT),
  localparam int unsigned VW = $clog2(V_TOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o,
  output logic          active_o,
  output logic          hsync_no,
  output logic          vsync_no,
  output logic          frame_end_o
);
  localparam int unsigned HS_BEG = H_ACT + H_FP;
  localparam int unsigned HS_END = HS_BEG + H_SW;
  localparam int unsigned VS_BEG = V_ACT + V_FP;
  localparam int unsigned VS_END = VS_BEG + V_SW;

  logic h_last, v_last;
  assign h_last = h_o == HW'(H_TOT-1);
  assign v_last = v_o == VW'(V_TOT-1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_o <= '0;
      v_o <= '0;
    end else if (adv_i) begin
      if (h_last) begin
        h_o <= '0;
        v_o <= v_last ? '0 : v_o + 1'b1;
      end else begin
        h_o <= h_o + 1'b1;
      end
    end
  end

  assign active_o    = (h_o < HW'(H_ACT)) && (v_o < VW'(V_ACT));
  assign hsync_no    = !((h_o >= HW'(HS_BEG)) && (h_o < HW'(HS_END)));
  assign vsync_no    = !((v_o >= VW'(VS_BEG)) && (v_o < VW'(VS_END)));
  assign frame_end_o = h_last && v_last;

  assert_hs_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hsync_no) |-> h_o == HW'(HS_BEG));
  assert_hs_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_no) |-> h_o == HW'(HS_END % H_TOT));
  assert_vs_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vsync_no) |-> v_o == VW'(VS_BEG));
endmodule

// File: rtl/sram_fb_scanout.sv
module sram_fb_scanout
  import sram_fb_pkg::*;
#(
  parameter int unsigned H_ACT  = 640,
  parameter int unsigned H_FP   = 16,
  parameter int unsigned H_SW   = 96,
  parameter int unsigned H_BP   = 48,
  parameter int unsigned V_ACT  = 480,
  parameter int unsigned V_FP   = 10,
  parameter int unsigned V_SW   = 2,
  parameter int unsigned V_BP   = 33,
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned PIX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_sck_i,
  input  logic              spi_cs_ni,
  input  logic              spi_mosi_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  input  logic [PIX_W-1:0]  sram_dq_i,
  output logic [PIX_W-1:0]  sram_dq_o,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  output logic [PIX_W-1:0]  pix_o,
  output logic              hsync_no,
  output logic              vsync_no
);
  localparam int unsigned H_TOT = H_ACT + H_FP + H_SW + H_BP;
  localparam int unsigned V_TOT = V_ACT + V_FP + V_SW + V_BP;
  localparam int unsigned HW = $clog2(H_TOT);
  localparam int unsigned VW = $clog2(V_TOT);
  localparam int unsigned FB_PIX = H_ACT * V_ACT;

  slot_e             slot_q;
  logic              adv;
  logic [HW-1:0]     h;
  logic [VW-1:0]     v;
  logic              active, hs_n, vs_n, frame_end;
  logic              spi_start, byte_vld;
  logic [PIX_W-1:0]  rx_byte;
  logic [ADDR_W-1:0] rd_addr_q, wr_addr_q;
  logic [PIX_W-1:0]  wdat_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= SLOT_RD;
    else         slot_q <= (slot_q == SLOT_RD) ? SLOT_WR : SLOT_RD;
  end

  assign adv = slot_q == SLOT_WR;

  fb_raster #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP)
  ) i_raster (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .h_o        (h),
    .v_o        (v),
    .active_o   (active),
    .hsync_no   (hs_n),
    .vsync_no   (vs_n),
    .frame_end_o(frame_end)
  );

  fb_spi_rx #(.DATA_W(PIX_W)) i_spi_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_i     (spi_sck_i),
    .cs_ni     (spi_cs_ni),
    .mosi_i    (spi_mosi_i),
    .start_o   (spi_start),
    .byte_vld_o(byte_vld),
    .byte_o    (rx_byte)
  );

  // Running scan address; advances once per visible pixel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rd_addr_q <= '0;
    else if (adv) begin
      if (frame_end)     rd_addr_q <= '0;
      else if (active)   rd_addr_q <= rd_addr_q + 1'b1;
    end
  end

  // One-byte write holding slot; serviced in the next write cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      wdat_q    <= '0;
      wr_addr_q <= '0;
    end else begin
      if (byte_vld) begin
        pend_q <= 1'b1;
        wdat_q <= rx_byte;
      end else if (adv && pend_q) begin
        pend_q <= 1'b0;
      end
      if (spi_start)
        wr_addr_q <= '0;
      else if (adv && pend_q)
        wr_addr_q <= (wr_addr_q == ADDR_W'(FB_PIX-1)) ? '0 : wr_addr_q + 1'b1;
    end
  end

  assign sram_addr_o = (slot_q == SLOT_RD) ? rd_addr_q : wr_addr_q;
  assign sram_oe_no  = !((slot_q == SLOT_RD) && active);
  assign sram_we_no  = !((slot_q == SLOT_WR) && pend_q);
  assign sram_dq_o   = wdat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o    <= '0;
      hsync_no <= 1'b1;
      vsync_no <= 1'b1;
    end else if (slot_q == SLOT_RD) begin
      pix_o    <= active ? sram_dq_i : '0;
      hsync_no <= hs_n;
      vsync_no <= vs_n;
    end
  end

  assert_strobe_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_oe_no && !sram_we_no));
  assert_write_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |=> sram_we_no);
  assert_blank_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_oe_no && slot_q == SLOT_RD) |=> pix_o == '0);
  assert_cs_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_start |=> wr_addr_q == '0);
  assert_wr_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_addr_q < ADDR_W'(FB_PIX));
endmodule

// File: tb/test_sram_fb_scanout.sv
module test_sram_fb_scanout;
  localparam int CLK_PERIOD = 10;
  localparam int H_ACT = 8, H_FP = 2, H_SW = 3, H_BP = 2;
  localparam int V_ACT = 6, V_FP = 1, V_SW = 2, V_BP = 2;
  localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP;
  localparam int FB = H_ACT * V_ACT;
  localparam int HP = 3;

  logic        clk = 0, rst_n = 0;
  logic        sck = 0, cs_n = 1, mosi = 0;
  logic [18:0] addr;
  logic [7:0]  dq_i, dq_o, pix;
  logic        oe_n, we_n, hs_n, vs_n;

  logic [7:0]  mem [0:63];
  logic [7:0]  sent_q [$];
  int          k, exp_waddr;
  int          checks = 0, errors = 0;
  logic [7:0]  exp_pix;
  logic        exp_hs, exp_vs;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_fb_scanout #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP)
  ) i_sram_fb_scanout (
    .clk_i(clk), .rst_ni(rst_n),
    .spi_sck_i(sck), .spi_cs_ni(cs_n), .spi_mosi_i(mosi),
    .sram_addr_o(addr), .sram_dq_i(dq_i), .sram_dq_o(dq_o),
    .sram_oe_no(oe_n), .sram_we_no(we_n),
    .pix_o(pix), .hsync_no(hs_n), .vsync_no(vs_n)
  );

  assign dq_i = mem[addr[5:0]];

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at t=%0t", tag, act, expv, $time);
    end
  endtask

  // SRAM model and cycle counter
  always @(posedge clk) begin
    if (!rst_n) begin
      k <= 0;
      for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 7 + 3);
    end else begin
      k <= k + 1;
      if (!we_n) mem[addr[5:0]] <= dq_o;
    end
  end

  // Reference model, compared on every clock
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(pix == 0, "R1 pix", pix, 0);
      chk(hs_n && vs_n, "R1 sync", {hs_n, vs_n}, 3);
      chk(we_n, "R1 we", we_n, 1);
      exp_pix = 0; exp_hs = 1; exp_vs = 1;
    end else begin
      int p, h, v;
      if (k % 2 == 1) begin
        p = (k - 1) / 2;
        h = p % H_TOT;
        v = (p / H_TOT) % V_TOT;
        exp_pix = (h < H_ACT && v < V_ACT) ? mem[v * H_ACT + h] : 8'd0;
        exp_hs  = !(h >= H_ACT + H_FP && h < H_ACT + H_FP + H_SW);
        exp_vs  = !(v >= V_ACT + V_FP && v < V_ACT + V_FP + V_SW);
        chk(pix == exp_pix, (h < H_ACT && v < V_ACT) ? "R3 pixel" : "R4 blank", pix, exp_pix);
      end else begin
        chk(pix == exp_pix, "R3 pixel hold", pix, exp_pix);
      end
      chk(hs_n == exp_hs, "R5 hsync", hs_n, exp_hs);
      chk(vs_n == exp_vs, "R6 vsync", vs_n, exp_vs);
      p = k / 2;
      h = p % H_TOT;
      v = (p / H_TOT) % V_TOT;
      if (!oe_n) begin
        chk(k % 2 == 0, "R2 read slot", k % 2, 0);
        chk(h < H_ACT && v < V_ACT, "R4 read in blank", h, v);
        chk(int'(addr) == v * H_ACT + h, "R3 read addr", addr, v * H_ACT + h);
      end
      if (!we_n) begin
        chk(k % 2 == 1, "R2 write slot", k % 2, 1);
        chk(oe_n, "R2 strobe overlap", oe_n, 1);
        chk(sent_q.size() > 0, "R10 unexpected write", sent_q.size(), 1);
        if (sent_q.size() > 0) begin
          chk(dq_o == sent_q[0], "R7 write data", dq_o, sent_q[0]);
          void'(sent_q.pop_front());
        end
        chk(int'(addr) == exp_waddr, "R9 write addr", addr, exp_waddr);
        exp_waddr = (exp_waddr + 1) % FB;
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_begin();
    @(negedge clk);
    cs_n = 0;
    exp_waddr = 0;
    wait_clk(2 * HP);
  endtask

  task automatic spi_bits(input logic [7:0] b, input int nbits);
    if (nbits == 8) sent_q.push_back(b);
    for (int i = 0; i < nbits; i++) begin
      mosi = b[7 - i];
      wait_clk(HP);
      sck = 1;
      wait_clk(HP);
      sck = 0;
    end
  endtask

  task automatic spi_end();
    wait_clk(2 * HP);
    cs_n = 1;
    wait_clk(4 * HP);
  endtask

  initial begin
    fork
      begin
        wait_clk(100000);
        chk(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    exp_waddr = 0;
    wait_clk(5);
    rst_n = 1;
    // idle frame shows initial memory
    wait_clk(2 * H_TOT * V_TOT);
    // R10: clocking with chip select high
    for (int i = 0; i < 16; i++) begin
      mosi = i[0];
      wait_clk(HP); sck = 1; wait_clk(HP); sck = 0;
    end
    wait_clk(20);
    // R7: plain transfer
    spi_begin();
    spi_bits(8'hA5, 8); spi_bits(8'h3C, 8); spi_bits(8'hFF, 8);
    spi_bits(8'h00, 8); spi_bits(8'h81, 8);
    spi_end();
    chk(sent_q.size() == 0, "R7 bytes written", sent_q.size(), 0);
    // R8: partial byte abandoned, then restart at address 0
    spi_begin();
    spi_bits(8'hE0, 3);
    spi_end();
    spi_begin();
    spi_bits(8'h5A, 8); spi_bits(8'hC3, 8);
    spi_end();
    chk(sent_q.size() == 0, "R8 bytes written", sent_q.size(), 0);
    // R9: stream past the end of the frame
    spi_begin();
    for (int i = 0; i < FB + 2; i++) spi_bits(8'(i * 13 + 1), 8);
    spi_end();
    chk(sent_q.size() == 0, "R9 bytes written", sent_q.size(), 0);
    chk(mem[0] == 8'(FB * 13 + 1), "R9 wrap content", mem[0], 8'(FB * 13 + 1));
    wait_clk(4 * H_TOT * V_TOT);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule